// File: doc/BRIEF.md
# Electromagnetic Candidate Validation and Selection

Each bunch crossing, this block takes up to eight electromagnetic cluster candidates, one per front-end tile. It validates each one against a writable classification table that is indexed by the candidate's preshower and charge-detector bits. From the validated candidates it picks the best electron and the best photon. It also forms two neutral-pion candidates: the tile with the largest total energy, and the best energy sum of two neighbouring tiles. In the same pass it adds matching electromagnetic energy onto up to four hadronic candidates.

Each crossing is marked by a valid strobe. All of its results appear together two clock edges later, tagged with the crossing identifier. Between crossings the table is loaded one entry per clock through a plain write port. The pipeline has fixed latency and does not depend on occupancy, so results line up with the crossing stream.

Top module: `em_cluster_select`

## Requirements
- R1: While reset is asserted and after it is released, outValid is 0 and every energy and address output is 0 until the first crossing is published.
- R2: A crossing presented with xValid high at clock edge k drives outValid high for exactly one cycle after edge k+1, with outBx equal to that crossing's bxId. When no result is published, all outputs hold their values.
- R3: A tile's table index is {tileVal[7:0], localAddr[1:0]}, with the validation bits in index bits 9:2. In the 8-bit table word, bit 0 marks an electron and bit 1 marks a photon. A write with lutWe high stores lutWdata at lutWaddr on the clock edge.
- R4: eleEt/eleAddr give the highest energy among present tiles marked as electrons. The address is {tile index[2:0], localAddr[4:0]}.
- R5: phoEt/phoAddr give the same selection among present tiles marked as photons.
- R6: When several candidates share the highest energy, the lowest tile index wins. This applies in every selection, including the neighbour pairs.
- R7: When no present tile qualifies for a selection, its energy and address outputs are 0.
- R8: locPiEt/locPiAddr give the largest tileTot among present tiles, with that tile's address.
- R9: gloPiEt is the highest sum over neighbour pairs (i, i+1) in which both tiles are present. The sum saturates at 255. gloPiAddr is the address of the lower tile of the winning pair.
- R10: Each hadronic candidate h outputs hadEt[h] plus the energy of the lowest-index present tile whose 5-bit local address equals hadAddr[h], saturating at 255. With no match, hadEt[h] is output unchanged.
- R11: A tile whose tilePresent bit is 0 takes part in no selection, no pair and no hadronic match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| xValid | input | 1 | Crossing data valid this cycle |
| bxId | input | 8 | Crossing identifier |
| tilePresent | input | 8 | One bit per tile: candidate present |
| tileEt | input | 64 | Candidate energy, 8 bits per tile |
| tileAddr | input | 40 | Local address, 5 bits per tile |
| tileVal | input | 64 | Preshower (low 4) and charge (high 4) bits per tile |
| tileTot | input | 64 | Tile total energy, 8 bits per tile |
| hadEt | input | 32 | Hadronic candidate energy, 8 bits each |
| hadAddr | input | 20 | Hadronic candidate address, 5 bits each |
| lutWe | input | 1 | Table write enable |
| lutWaddr | input | 10 | Table write index |
| lutWdata | input | 8 | Table write word |
| outValid | output | 1 | Results published this cycle |
| outBx | output | 8 | Identifier of the published crossing |
| eleEt | output | 8 | Best electron energy |
| eleAddr | output | 8 | Best electron address |
| phoEt | output | 8 | Best photon energy |
| phoAddr | output | 8 | Best photon address |
| locPiEt | output | 8 | Largest tile total energy |
| locPiAddr | output | 8 | Address of that tile |
| gloPiEt | output | 8 | Best neighbour-pair sum |
| gloPiAddr | output | 8 | Address of the lower tile of that pair |
| hadSumEt | output | 32 | Hadronic energies with matched EM energy added |

## Verification
The hardest situation to reach from the ports is a hadronic address that matches several present tiles at once, where only the lowest one may be added, often together with equal-energy ties and absent tiles in between. With uniform addresses this almost never happens. Half of the random crossings therefore draw local addresses from only two values, and hadronic addresses are copied from tile addresses. Validation bits are drawn mostly from table rows with a known fixed class. Directed crossings cover full ties, saturation, empty selections and a table rewrite.

// File: rtl/emsel_pkg.sv
package emsel_pkg;
  localparam int DEF_NTILE  = 8;
  localparam int DEF_NHAD   = 4;
  localparam int DEF_ET_W   = 8;
  localparam int DEF_LA_W   = 5;
  localparam int DEF_VB_W   = 8;
  localparam int DEF_LUT_DW = 8;

  // Pipeline strobes from control to datapath
  typedef struct packed {
    logic capture;  // load stage 1 from the ports
    logic publish;  // load outputs from stage 1
  } emselStrobe_t;
endpackage

// File: rtl/emsel_control.sv
module emsel_control
  import emsel_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         xValid,
  output emselStrobe_t strobe,
  output logic         outValid
);
  logic s1Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      s1Valid  <= xValid;
      outValid <= s1Valid;
    end
  end

  always_comb begin
    strobe.capture = xValid;
    strobe.publish = s1Valid;
  end
endmodule

// File: rtl/emsel_maxpick.sv
module emsel_maxpick #(
  parameter int N      = 8,
  parameter int ET_W   = 8,
  parameter int ADDR_W = 8
) (
  input  logic [N-1:0]        candV,
  input  logic [N*ET_W-1:0]   candEt,
  input  logic [N*ADDR_W-1:0] candAddr,
  output logic [ET_W-1:0]     bestEt,
  output logic [ADDR_W-1:0]   bestAddr
);
  logic bestV;

  // Cascade in index order; strict compare keeps the lower index on ties
  always_comb begin
    bestV    = 1'b0;
    bestEt   = '0;
    bestAddr = '0;
    for (int i = 0; i < N; i++) begin
      if (candV[i] && (!bestV || candEt[i*ET_W +: ET_W] > bestEt)) begin
        bestV    = 1'b1;
        bestEt   = candEt[i*ET_W +: ET_W];
        bestAddr = candAddr[i*ADDR_W +: ADDR_W];
      end
    end
  end
endmodule

// File: rtl/emsel_datapath.sv
module emsel_datapath
  import emsel_pkg::*;
#(
  parameter int NTILE  = DEF_NTILE,
  parameter int NHAD   = DEF_NHAD,
  parameter int ET_W   = DEF_ET_W,
  parameter int LA_W   = DEF_LA_W,
  parameter int VB_W   = DEF_VB_W,
  parameter int LUT_DW = DEF_LUT_DW,
  localparam int TILE_W = $clog2(NTILE),
  localparam int ADDR_W = TILE_W + LA_W,
  localparam int LUT_AW = VB_W + 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  emselStrobe_t             strobe,
  input  logic [7:0]               bxId,
  input  logic [NTILE-1:0]         tilePresent,
  input  logic [NTILE*ET_W-1:0]    tileEt,
  input  logic [NTILE*LA_W-1:0]    tileAddr,
  input  logic [NTILE*VB_W-1:0]    tileVal,
  input  logic [NTILE*ET_W-1:0]    tileTot,
  input  logic [NHAD*ET_W-1:0]     hadEt,
  input  logic [NHAD*LA_W-1:0]     hadAddr,
  input  logic                     lutWe,
  input  logic [LUT_AW-1:0]        lutWaddr,
  input  logic [LUT_DW-1:0]        lutWdata,
  output logic [7:0]               outBx,
  output logic [ET_W-1:0]          eleEt,
  output logic [ADDR_W-1:0]        eleAddr,
  output logic [ET_W-1:0]          phoEt,
  output logic [ADDR_W-1:0]        phoAddr,
  output logic [ET_W-1:0]          locPiEt,
  output logic [ADDR_W-1:0]        locPiAddr,
  output logic [ET_W-1:0]          gloPiEt,
  output logic [ADDR_W-1:0]        gloPiAddr,
  output logic [NHAD*ET_W-1:0]     hadSumEt
);
  localparam int LUT_DEPTH = 1 << LUT_AW;
  localparam int NPAIR     = NTILE - 1;

  function automatic logic [ET_W-1:0] satAdd(input logic [ET_W-1:0] a,
                                             input logic [ET_W-1:0] b);
    logic [ET_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[ET_W] ? {ET_W{1'b1}} : s[ET_W-1:0];
  endfunction

  // Classification table
  logic [LUT_DW-1:0] lutMem [LUT_DEPTH];
  always_ff @(posedge clk) begin
    if (lutWe) lutMem[lutWaddr] <= lutWdata;
  end

  // Per-tile classification and full address
  logic [NTILE-1:0]        eleNow, phoNow;
  logic [NTILE*ADDR_W-1:0] addrNow;
  logic [NTILE-1:0]        unusedLutHi;

  for (genvar t = 0; t < NTILE; t++) begin : g_tile
    logic [LUT_AW-1:0] idx;
    logic [LUT_DW-1:0] word;
    assign idx  = {tileVal[t*VB_W +: VB_W], tileAddr[t*LA_W +: 2]};
    assign word = lutMem[idx];
    assign eleNow[t] = tilePresent[t] & word[0];
    assign phoNow[t] = tilePresent[t] & word[1];
    assign addrNow[t*ADDR_W +: ADDR_W] = {TILE_W'(t), tileAddr[t*LA_W +: LA_W]};
    assign unusedLutHi[t] = ^word[LUT_DW-1:2];
  end

  // Neighbour pairs
  logic [NPAIR-1:0]        pairV;
  logic [NPAIR*ET_W-1:0]   pairEt;
  logic [NPAIR*ADDR_W-1:0] pairAddr;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign pairV[p] = tilePresent[p] & tilePresent[p+1];
    assign pairEt[p*ET_W +: ET_W] =
      satAdd(tileEt[p*ET_W +: ET_W], tileEt[(p+1)*ET_W +: ET_W]);
    assign pairAddr[p*ADDR_W +: ADDR_W] = addrNow[p*ADDR_W +: ADDR_W];
  end

  // Hadronic energy add: first present tile with matching address
  logic [NHAD*ET_W-1:0] hadNow;
  always_comb begin
    logic hit;
    logic [ET_W-1:0] acc;
    hadNow = '0;
    for (int h = 0; h < NHAD; h++) begin
      hit = 1'b0;
      acc = hadEt[h*ET_W +: ET_W];
      for (int t = 0; t < NTILE; t++) begin
        if (!hit && tilePresent[t] &&
            tileAddr[t*LA_W +: LA_W] == hadAddr[h*LA_W +: LA_W]) begin
          hit = 1'b1;
          acc = satAdd(acc, tileEt[t*ET_W +: ET_W]);
        end
      end
      hadNow[h*ET_W +: ET_W] = acc;
    end
  end

  // Stage 1 registers
  logic [NTILE-1:0]        s1Ele, s1Pho, s1Pres;
  logic [NTILE*ET_W-1:0]   s1Et, s1Tot;
  logic [NTILE*ADDR_W-1:0] s1Addr;
  logic [NPAIR-1:0]        s1PairV;
  logic [NPAIR*ET_W-1:0]   s1PairEt;
  logic [NPAIR*ADDR_W-1:0] s1PairAddr;
  logic [NHAD*ET_W-1:0]    s1Had;
  logic [7:0]              s1Bx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Ele <= '0; s1Pho <= '0; s1Pres <= '0;
      s1Et <= '0; s1Tot <= '0; s1Addr <= '0;
      s1PairV <= '0; s1PairEt <= '0; s1PairAddr <= '0;
      s1Had <= '0; s1Bx <= '0;
    end else if (strobe.capture) begin
      s1Ele <= eleNow; s1Pho <= phoNow; s1Pres <= tilePresent;
      s1Et <= tileEt; s1Tot <= tileTot; s1Addr <= addrNow;
      s1PairV <= pairV; s1PairEt <= pairEt; s1PairAddr <= pairAddr;
      s1Had <= hadNow; s1Bx <= bxId;
    end
  end

  // Selection trees
  logic [ET_W-1:0]   selEleEt, selPhoEt, selLocEt, selGloEt;
  logic [ADDR_W-1:0] selEleAddr, selPhoAddr, selLocAddr, selGloAddr;

  emsel_maxpick #(.N(NTILE), .ET_W(ET_W), .ADDR_W(ADDR_W)) u_pickEle (
    .candV(s1Ele), .candEt(s1Et), .candAddr(s1Addr),
    .bestEt(selEleEt), .bestAddr(selEleAddr));

  emsel_maxpick #(.N(NTILE), .ET_W(ET_W), .ADDR_W(ADDR_W)) u_pickPho (
    .candV(s1Pho), .candEt(s1Et), .candAddr(s1Addr),
    .bestEt(selPhoEt), .bestAddr(selPhoAddr));

  emsel_maxpick #(.N(NTILE), .ET_W(ET_W), .ADDR_W(ADDR_W)) u_pickLoc (
    .candV(s1Pres), .candEt(s1Tot), .candAddr(s1Addr),
    .bestEt(selLocEt), .bestAddr(selLocAddr));

  emsel_maxpick #(.N(NPAIR), .ET_W(ET_W), .ADDR_W(ADDR_W)) u_pickGlo (
    .candV(s1PairV), .candEt(s1PairEt), .candAddr(s1PairAddr),
    .bestEt(selGloEt), .bestAddr(selGloAddr));

  // Output registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outBx <= '0;
      eleEt <= '0; eleAddr <= '0;
      phoEt <= '0; phoAddr <= '0;
      locPiEt <= '0; locPiAddr <= '0;
      gloPiEt <= '0; gloPiAddr <= '0;
      hadSumEt <= '0;
    end else if (strobe.publish) begin
      outBx <= s1Bx;
      eleEt <= selEleEt; eleAddr <= selEleAddr;
      phoEt <= selPhoEt; phoAddr <= selPhoAddr;
      locPiEt <= selLocEt; locPiAddr <= selLocAddr;
      gloPiEt <= selGloEt; gloPiAddr <= selGloAddr;
      hadSumEt <= s1Had;
    end
  end
endmodule

// File: rtl/em_cluster_select.sv
module em_cluster_select
  import emsel_pkg::*;
#(
  parameter int NTILE  = DEF_NTILE,
  parameter int NHAD   = DEF_NHAD,
  parameter int ET_W   = DEF_ET_W,
  parameter int LA_W   = DEF_LA_W,
  parameter int VB_W   = DEF_VB_W,
  parameter int LUT_DW = DEF_LUT_DW,
  localparam int TILE_W = $clog2(NTILE),
  localparam int ADDR_W = TILE_W + LA_W,
  localparam int LUT_AW = VB_W + 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  xValid,
  input  logic [7:0]            bxId,
  input  logic [NTILE-1:0]      tilePresent,
  input  logic [NTILE*ET_W-1:0] tileEt,
  input  logic [NTILE*LA_W-1:0] tileAddr,
  input  logic [NTILE*VB_W-1:0] tileVal,
  input  logic [NTILE*ET_W-1:0] tileTot,
  input  logic [NHAD*ET_W-1:0]  hadEt,
  input  logic [NHAD*LA_W-1:0]  hadAddr,
  input  logic                  lutWe,
  input  logic [LUT_AW-1:0]     lutWaddr,
  input  logic [LUT_DW-1:0]     lutWdata,
  output logic                  outValid,
  output logic [7:0]            outBx,
  output logic [ET_W-1:0]       eleEt,
  output logic [ADDR_W-1:0]     eleAddr,
  output logic [ET_W-1:0]       phoEt,
  output logic [ADDR_W-1:0]     phoAddr,
  output logic [ET_W-1:0]       locPiEt,
  output logic [ADDR_W-1:0]     locPiAddr,
  output logic [ET_W-1:0]       gloPiEt,
  output logic [ADDR_W-1:0]     gloPiAddr,
  output logic [NHAD*ET_W-1:0]  hadSumEt
);
  emselStrobe_t strobe;

  emsel_control u_control (
    .clk(clk), .rstN(rstN), .xValid(xValid),
    .strobe(strobe), .outValid(outValid));

  emsel_datapath #(
    .NTILE(NTILE), .NHAD(NHAD), .ET_W(ET_W), .LA_W(LA_W),
    .VB_W(VB_W), .LUT_DW(LUT_DW)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bxId(bxId),
    .tilePresent(tilePresent), .tileEt(tileEt), .tileAddr(tileAddr),
    .tileVal(tileVal), .tileTot(tileTot), .hadEt(hadEt), .hadAddr(hadAddr),
    .lutWe(lutWe), .lutWaddr(lutWaddr), .lutWdata(lutWdata),
    .outBx(outBx), .eleEt(eleEt), .eleAddr(eleAddr),
    .phoEt(phoEt), .phoAddr(phoAddr), .locPiEt(locPiEt), .locPiAddr(locPiAddr),
    .gloPiEt(gloPiEt), .gloPiAddr(gloPiAddr), .hadSumEt(hadSumEt));
endmodule

// File: rtl/em_cluster_select_chk.sv
module em_cluster_select_chk #(
  parameter int NTILE  = 8,
  parameter int NHAD   = 4,
  parameter int ET_W   = 8,
  parameter int TILE_W = 3,
  parameter int ADDR_W = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 xValid,
  input logic [NTILE-1:0]     tilePresent,
  input logic [NHAD*ET_W-1:0] hadEt,
  input logic                 outValid,
  input logic [ET_W-1:0]      eleEt,
  input logic [ADDR_W-1:0]    eleAddr,
  input logic [ET_W-1:0]      phoEt,
  input logic [ADDR_W-1:0]    phoAddr,
  input logic [NHAD*ET_W-1:0] hadSumEt
);
  logic d1, d2;
  logic [NTILE-1:0]     pres1, pres2;
  logic [NHAD*ET_W-1:0] had1, had2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      d1 <= 1'b0; d2 <= 1'b0;
      pres1 <= '0; pres2 <= '0; had1 <= '0; had2 <= '0;
    end else begin
      d1 <= xValid;
      d2 <= d1;
      if (xValid) begin pres1 <= tilePresent; had1 <= hadEt; end
      if (d1)     begin pres2 <= pres1;       had2 <= had1;  end
    end
  end

  // R2: published exactly two edges after the crossing
  a_r2_latency: assert property (@(posedge clk) disable iff (!rstN)
    outValid == d2);

  // R2: outputs hold without a publish
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(eleEt) && $stable(phoEt) && $stable(hadSumEt)));

  // R4, R11: a nonzero electron comes from a present tile
  a_r4_ele_present: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && eleEt != '0) |-> pres2[eleAddr[ADDR_W-1 -: TILE_W]]);

  // R5, R11: a nonzero photon comes from a present tile
  a_r5_pho_present: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && phoEt != '0) |-> pres2[phoAddr[ADDR_W-1 -: TILE_W]]);

  // R10: the add never lowers a hadronic energy
  for (genvar h = 0; h < NHAD; h++) begin : g_had
    a_r10_had_floor: assert property (@(posedge clk) disable iff (!rstN)
      outValid |-> (hadSumEt[h*ET_W +: ET_W] >= had2[h*ET_W +: ET_W]));
  end
endmodule

bind em_cluster_select em_cluster_select_chk #(
  .NTILE(NTILE), .NHAD(NHAD), .ET_W(ET_W), .TILE_W(TILE_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .xValid(xValid), .tilePresent(tilePresent),
  .hadEt(hadEt), .outValid(outValid), .eleEt(eleEt), .eleAddr(eleAddr),
  .phoEt(phoEt), .phoAddr(phoAddr), .hadSumEt(hadSumEt));

// File: tb/em_cluster_select_bench.sv
module em_cluster_select_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic xValid = 1'b0;
  logic [7:0]  bxId = '0;
  logic [7:0]  tilePresent = '0;
  logic [63:0] tileEt = '0, tileVal = '0, tileTot = '0;
  logic [39:0] tileAddr = '0;
  logic [31:0] hadEt = '0;
  logic [19:0] hadAddr = '0;
  logic        lutWe = 1'b0;
  logic [9:0]  lutWaddr = '0;
  logic [7:0]  lutWdata = '0;
  logic        outValid;
  logic [7:0]  outBx, eleEt, eleAddr, phoEt, phoAddr;
  logic [7:0]  locPiEt, locPiAddr, gloPiEt, gloPiAddr;
  logic [31:0] hadSumEt;

  always #2 clk = ~clk;

  em_cluster_select u_em_cluster_select (
    .clk(clk), .rstN(rstN), .xValid(xValid), .bxId(bxId),
    .tilePresent(tilePresent), .tileEt(tileEt), .tileAddr(tileAddr),
    .tileVal(tileVal), .tileTot(tileTot), .hadEt(hadEt), .hadAddr(hadAddr),
    .lutWe(lutWe), .lutWaddr(lutWaddr), .lutWdata(lutWdata),
    .outValid(outValid), .outBx(outBx), .eleEt(eleEt), .eleAddr(eleAddr),
    .phoEt(phoEt), .phoAddr(phoAddr), .locPiEt(locPiEt), .locPiAddr(locPiAddr),
    .gloPiEt(gloPiEt), .gloPiAddr(gloPiAddr), .hadSumEt(hadSumEt));

  int nRun = 0, nFail = 0;
  bit done = 1'b0;
  logic [7:0] benchLut [1024];
  int expBx, expEle, expEleA, expPho, expPhoA, expLoc, expLocA, expGlo, expGloA;
  int expHad [4];

  task automatic chk(input string tag, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] lutInit(input int i);
    case (i >> 2)
      8'h00:   return 8'h01;  // electron only
      8'hFF:   return 8'h02;  // photon only
      8'hA5:   return 8'h03;  // both
      8'h5A:   return 8'h00;  // neither
      default: return 8'((i * 97 + 13) ^ (i >> 3));
    endcase
  endfunction

  task automatic writeLut(input int idx, input logic [7:0] d);
    @(negedge clk);
    lutWe = 1'b1; lutWaddr = 10'(idx); lutWdata = d;
    benchLut[idx] = d;
    @(posedge clk);
    @(negedge clk);
    lutWe = 1'b0;
  endtask

  task automatic setTile(input int t, input bit p, input int et, input int ad,
                         input int vb, input int tot);
    tilePresent[t] = p;
    tileEt[t*8 +: 8] = 8'(et);
    tileAddr[t*5 +: 5] = 5'(ad);
    tileVal[t*8 +: 8] = 8'(vb);
    tileTot[t*8 +: 8] = 8'(tot);
  endtask

  function automatic int sat(input int v);
    return (v > 255) ? 255 : v;
  endfunction

  // Reference model from the requirements
  task automatic computeExp();
    bit fe, fp, fl, fg;
    expBx = int'(bxId);
    expEle = 0; expEleA = 0; expPho = 0; expPhoA = 0;
    expLoc = 0; expLocA = 0; expGlo = 0; expGloA = 0;
    fe = 0; fp = 0; fl = 0; fg = 0;
    for (int t = 0; t < 8; t++) begin
      int et, ad, w, tot;
      if (!tilePresent[t]) continue;
      et  = int'(tileEt[t*8 +: 8]);
      ad  = t * 32 + int'(tileAddr[t*5 +: 5]);
      tot = int'(tileTot[t*8 +: 8]);
      w   = int'(benchLut[int'(tileVal[t*8 +: 8]) * 4 + int'(tileAddr[t*5 +: 2])]);
      if ((w & 1) != 0 && (!fe || et > expEle)) begin fe = 1; expEle = et; expEleA = ad; end
      if ((w & 2) != 0 && (!fp || et > expPho)) begin fp = 1; expPho = et; expPhoA = ad; end
      if (!fl || tot > expLoc) begin fl = 1; expLoc = tot; expLocA = ad; end
    end
    for (int p = 0; p < 7; p++) begin
      int s;
      if (!(tilePresent[p] && tilePresent[p+1])) continue;
      s = sat(int'(tileEt[p*8 +: 8]) + int'(tileEt[(p+1)*8 +: 8]));
      if (!fg || s > expGlo) begin
        fg = 1; expGlo = s; expGloA = p * 32 + int'(tileAddr[p*5 +: 5]);
      end
    end
    for (int h = 0; h < 4; h++) begin
      expHad[h] = int'(hadEt[h*8 +: 8]);
      for (int t = 0; t < 8; t++) begin
        if (tilePresent[t] && tileAddr[t*5 +: 5] == hadAddr[h*5 +: 5]) begin
          expHad[h] = sat(expHad[h] + int'(tileEt[t*8 +: 8]));
          break;
        end
      end
    end
  endtask

  task automatic checkAll();
    chk("R2 outValid", int'(outValid), 1);
    chk("R2 outBx", int'(outBx), expBx);
    chk("R4 eleEt", int'(eleEt), expEle);
    chk("R4 eleAddr", int'(eleAddr), expEleA);
    chk("R5 phoEt", int'(phoEt), expPho);
    chk("R5 phoAddr", int'(phoAddr), expPhoA);
    chk("R8 locPiEt", int'(locPiEt), expLoc);
    chk("R8 locPiAddr", int'(locPiAddr), expLocA);
    chk("R9 gloPiEt", int'(gloPiEt), expGlo);
    chk("R9 gloPiAddr", int'(gloPiAddr), expGloA);
    for (int h = 0; h < 4; h++)
      chk("R10 hadSumEt", int'(hadSumEt[h*8 +: 8]), expHad[h]);
  endtask

  task automatic runOne(input int bx);
    @(negedge clk);
    bxId = 8'(bx); xValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    xValid = 1'b0;
    computeExp();
    @(posedge clk);
    @(negedge clk);
    checkAll();
  endtask

  task automatic clearTiles();
    tilePresent = '0; tileEt = '0; tileAddr = '0; tileVal = '0; tileTot = '0;
    hadEt = '0; hadAddr = '0;
  endtask

  task automatic randCrossing(input bit narrow);
    for (int t = 0; t < 8; t++) begin
      int vb, ad;
      case ($urandom % 6)
        0: vb = 8'h00;
        1: vb = 8'hFF;
        2: vb = 8'hA5;
        3: vb = 8'h5A;
        default: vb = int'($urandom % 256);
      endcase
      ad = narrow ? ((($urandom % 2) == 0) ? 3 : 7) : int'($urandom % 32);
      setTile(t, ($urandom % 4) != 0, int'($urandom % 256), ad, vb,
              int'($urandom % 256));
    end
    for (int h = 0; h < 4; h++) begin
      hadEt[h*8 +: 8] = 8'($urandom);
      if (($urandom % 2) == 0) hadAddr[h*5 +: 5] = tileAddr[($urandom % 8)*5 +: 5];
      else                     hadAddr[h*5 +: 5] = 5'($urandom);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    int savedEle, savedHad;
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    chk("R1 outValid in reset", int'(outValid), 0);
    chk("R1 eleEt in reset", int'(eleEt), 0);
    chk("R1 gloPiAddr in reset", int'(gloPiAddr), 0);
    rstN = 1'b1;
    for (int i = 0; i < 1024; i++) writeLut(i, lutInit(i));
    // R1 after release, before any crossing
    chk("R1 outValid idle", int'(outValid), 0);
    chk("R1 hadSumEt idle", int'(hadSumEt), 0);
    chk("R1 phoAddr idle", int'(phoAddr), 0);

    // R3: rewrite the row for val 00 / addr low bits 0 to photon-only
    writeLut(0, 8'h02);
    clearTiles();
    setTile(1, 1, 50, 4, 8'h00, 9);
    runOne(11);
    chk("R3 rewritten entry gives photon", int'(phoEt), 50);
    chk("R3 rewritten entry gives photon addr", int'(phoAddr), 8'h24);
    chk("R3 rewritten entry drops electron", int'(eleEt), 0);
    writeLut(0, 8'h01);

    // R6: full tie on every selection
    clearTiles();
    for (int t = 0; t < 8; t++) setTile(t, 1, 80, t + 8, 8'h00, 30);
    runOne(12);
    chk("R6 tie electron addr", int'(eleAddr), 8'h08);
    chk("R6 tie local pion addr", int'(locPiAddr), 8'h08);
    chk("R6 tie pair addr", int'(gloPiAddr), 8'h08);

    // R7: nothing classifies
    clearTiles();
    for (int t = 0; t < 8; t++) setTile(t, 1, 40 + t, t, 8'h5A, 5);
    runOne(13);
    chk("R7 empty electron et", int'(eleEt), 0);
    chk("R7 empty electron addr", int'(eleAddr), 0);
    chk("R7 empty photon et", int'(phoEt), 0);
    chk("R7 empty photon addr", int'(phoAddr), 0);

    // R9 / R10: saturation, no match, lowest matching tile
    clearTiles();
    for (int t = 0; t < 8; t++) setTile(t, 1, 0, t + 8, 8'h5A, 1);
    setTile(3, 1, 200, 11, 8'h5A, 1);
    setTile(4, 1, 200, 12, 8'h5A, 1);
    setTile(2, 1, 10, 20, 8'h5A, 1);
    setTile(6, 1, 90, 20, 8'h5A, 1);
    hadEt = {8'd5, 8'd5, 8'd77, 8'd250};
    hadAddr = {5'd0, 5'd20, 5'd31, 5'd11};
    runOne(14);
    chk("R9 pair sum saturates", int'(gloPiEt), 255);
    chk("R9 pair addr lower tile", int'(gloPiAddr), 8'h6B);
    chk("R10 saturating add", int'(hadSumEt[7:0]), 255);
    chk("R10 no match unchanged", int'(hadSumEt[15:8]), 77);
    chk("R10 lowest matching tile", int'(hadSumEt[23:16]), 15);

    // R11: absent tiles are ignored
    clearTiles();
    setTile(2, 1, 20, 6, 8'h00, 3);
    setTile(3, 0, 100, 7, 8'h00, 200);
    setTile(5, 0, 250, 9, 8'h00, 250);
    hadEt[7:0] = 8'd4; hadAddr[4:0] = 5'd9;
    runOne(15);
    chk("R11 electron from present tile", int'(eleAddr), 8'h46);
    chk("R11 electron et", int'(eleEt), 20);
    chk("R11 no pair", int'(gloPiEt), 0);
    chk("R11 absent tile not matched", int'(hadSumEt[7:0]), 4);
    chk("R11 local pion ignores absent", int'(locPiEt), 3);

    // R2: hold with no crossing
    savedEle = int'(eleEt);
    savedHad = int'(hadSumEt[7:0]);
    randCrossing(1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 no publish", int'(outValid), 0);
    chk("R2 hold eleEt", int'(eleEt), savedEle);
    chk("R2 hold hadSumEt", int'(hadSumEt[7:0]), savedHad);

    // R2: back-to-back crossings
    @(negedge clk);
    randCrossing(1'b1); bxId = 8'd21; xValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    computeExp();
    randCrossing(1'b0); bxId = 8'd22;
    @(posedge clk);
    @(negedge clk);
    checkAll();
    computeExp();
    xValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    checkAll();
    @(posedge clk);
    @(negedge clk);
    chk("R2 single-cycle valid", int'(outValid), 0);

    // Random crossings
    for (int k = 0; k < 300; k++) begin
      randCrossing(k[0]);
      runOne(int'($urandom % 256));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule